// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Detector

This block watches the already synchronized input levels of a GPIO controller and turns selected pin activity into one interrupt request and one wake request. Pins are grouped in banks of 32. Every bank has its own set of configuration words: which pins react to a rising transition, which to a falling one, which pins are level sensed instead of edge sensed, the active level of level-sensed pins, an interrupt enable mask and a wake enable mask.

Detected events are recorded in two sticky status banks. One is for interrupts and one is for wakes. Software clears them by writing ones. The interrupt line is raised while any recorded interrupt is enabled by its mask. The wake line is raised while any wake status bit is set. Configuration and status are reached through a simple single-cycle register port. Writes are taken on the clock edge, and read data is returned in the same cycle.

Top module: `gpio_irq_unit`

## Requirements
- R1: Six read/write configuration banks live at these byte offsets: rising enable 0x064, falling enable 0x07c, interrupt mask 0x0ac, input type 0x300, level polarity 0x318 and wake mask 0x400. The word for bank b is at offset+4*b, and its bit i belongs to pin 32*b+i. A read returns the current contents in the same cycle. Any other address reads zero, and a write to it changes nothing.
- R2: After reset every configuration and status bit is zero, and both irq_o and wake_o are low.
- R3: A pin with input-type bit 0 and rising enable 1 sets its interrupt status bit (offset 0x0c4) at the first clock edge that samples it high after it was sampled low. This happens once per transition, not while the pin stays high.
- R4: With falling enable 1 the same happens on a high-to-low transition. With both enables set, either transition sets the bit.
- R5: An edge-sensed pin with neither enable set never sets its status bit, whatever it does.
- R6: A pin with input-type bit 1 is level sensed. Polarity bit 0 makes high active and polarity bit 1 makes low active. The status bit is set at every clock edge that samples the active level. A clear written while the level stays active therefore has no lasting effect. Edge enables are ignored for such a pin.
- R7: Writing a 1 to a bit at 0x0c4 clears that status bit, and writing a 0 leaves it unchanged. If an event for the same pin is seen in the same cycle as the clear, the bit stays set.
- R8: Status bits record events whatever the mask holds. irq_o is high exactly when some status bit has its mask bit at 1, and it follows the registers after the same clock edge.
- R9: A wake status bit (offset 0x418, same bank layout) is set by a pin event only if that pin's wake mask bit is 1. It is cleared by writing one, with the same same-cycle rule as R7. wake_o is high exactly when some wake status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_level_i | input | NUM_PINS | Synchronized pin levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte address of the register word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, same cycle |
| irq_o | output | 1 | Combined enabled interrupt request |
| wake_o | output | 1 | Combined wake request |

## Verification
A wrong stored previous level shows up at the very next clock edge. It either records an edge that never happened or misses one, and the error is visible at once in the status word and, if the pin is unmasked, on irq_o. A lost or extra status bit stays wrong until it is cleared, so reading status back right after each stimulus cycle shows the fault within one cycle. A mistake in the mask or wake gating appears on irq_o or wake_o one edge after the event that exposes it. A mis-decoded address shows up as stale or unexpected data on the same-cycle read path.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int unsigned REG_ADDR_W = 12;
    localparam int unsigned BANK_W     = 32;
    localparam int unsigned NUM_KINDS  = 8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RISE,
        SEL_FALL,
        SEL_IMASK,
        SEL_ISTAT,
        SEL_LTYPE,
        SEL_LPOL,
        SEL_WMASK,
        SEL_WSTAT
    } reg_sel_e;

    // Base byte offsets of each register bank, bank stride 4 bytes.
    localparam logic [REG_ADDR_W-1:0] KIND_BASE [NUM_KINDS] = '{
        12'h064, 12'h07c, 12'h0ac, 12'h0c4,
        12'h300, 12'h318, 12'h400, 12'h418
    };

    localparam reg_sel_e KIND_SEL [NUM_KINDS] = '{
        SEL_RISE, SEL_FALL, SEL_IMASK, SEL_ISTAT,
        SEL_LTYPE, SEL_LPOL, SEL_WMASK, SEL_WSTAT
    };

endpackage

// File: rtl/gpio_irq_decode.sv
`timescale 1ns/1ps
module gpio_irq_decode
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BIDX_W    = 1
) (
    input  logic [REG_ADDR_W-1:0] addr_i,
    output reg_sel_e              sel_o,
    output logic [BIDX_W-1:0]     bank_o
);

    // Window covered by one register kind across all banks.
    localparam logic [REG_ADDR_W:0] WIN = (REG_ADDR_W+1)'(4 * NUM_BANKS);

    always_comb begin
        sel_o  = SEL_NONE;
        bank_o = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            if (addr_i[1:0] == 2'b00 &&
                addr_i >= KIND_BASE[k] &&
                {1'b0, addr_i} < ({1'b0, KIND_BASE[k]} + WIN)) begin
                sel_o  = KIND_SEL[k];
                bank_o = BIDX_W'((addr_i - KIND_BASE[k]) >> 2);
            end
        end
    end

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] rise_en_i,
    input  logic [WIDTH-1:0] fall_en_i,
    input  logic [WIDTH-1:0] ltype_i,
    input  logic [WIDTH-1:0] lpol_i,
    output logic [WIDTH-1:0] evt_o
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] went_up;
    logic [WIDTH-1:0] went_down;
    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] level_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
        end else begin
            prev_q <= pin_i;
        end
    end

    always_comb begin
        went_up   = pin_i & ~prev_q;
        went_down = ~pin_i & prev_q;
        edge_hit  = (went_up & rise_en_i) | (went_down & fall_en_i);
        level_hit = pin_i ^ lpol_i;
        evt_o     = (ltype_i & level_hit) | (~ltype_i & edge_hit);
    end

endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned BANK_IDX = 0,
    parameter int unsigned NUM_PINS = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BANK_W-1:0] pin_i,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] rise_o,
    output logic [BANK_W-1:0] fall_o,
    output logic [BANK_W-1:0] imask_o,
    output logic [BANK_W-1:0] istat_o,
    output logic [BANK_W-1:0] wmask_o,
    output logic [BANK_W-1:0] wstat_o,
    output logic [BANK_W-1:0] evt_o,
    output logic [BANK_W-1:0] iclr_o,
    output logic [BANK_W-1:0] wclr_o,
    output logic [BANK_W-1:0] rdata_o
);

    localparam int unsigned LO_PIN = BANK_IDX * BANK_W;
    localparam int unsigned USED   = (NUM_PINS - LO_PIN >= BANK_W) ? BANK_W : (NUM_PINS - LO_PIN);
    localparam logic [BANK_W-1:0] VALID =
        (USED == BANK_W) ? {BANK_W{1'b1}} : BANK_W'((64'd1 << USED) - 64'd1);

    logic [BANK_W-1:0] rise_q, fall_q, imask_q, istat_q;
    logic [BANK_W-1:0] ltype_q, lpol_q, wmask_q, wstat_q;
    logic [BANK_W-1:0] wd;
    logic [BANK_W-1:0] evt;
    logic [BANK_W-1:0] iclr, wclr;

    assign wd = wdata_i & VALID;

    gpio_irq_detect #(.WIDTH(BANK_W)) det_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_i     (pin_i & VALID),
        .rise_en_i (rise_q),
        .fall_en_i (fall_q),
        .ltype_i   (ltype_q),
        .lpol_i    (lpol_q),
        .evt_o     (evt)
    );

    always_comb begin
        iclr = (wr_i && sel_i == SEL_ISTAT) ? wd : '0;
        wclr = (wr_i && sel_i == SEL_WSTAT) ? wd : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rise_q  <= '0;
            fall_q  <= '0;
            imask_q <= '0;
            ltype_q <= '0;
            lpol_q  <= '0;
            wmask_q <= '0;
        end else if (wr_i) begin
            case (sel_i)
                SEL_RISE:  rise_q  <= wd;
                SEL_FALL:  fall_q  <= wd;
                SEL_IMASK: imask_q <= wd;
                SEL_LTYPE: ltype_q <= wd;
                SEL_LPOL:  lpol_q  <= wd;
                SEL_WMASK: wmask_q <= wd;
                default:   ;
            endcase
        end
    end

    // Sticky status: a new event outranks a clear of the same bit.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            istat_q <= '0;
            wstat_q <= '0;
        end else begin
            istat_q <= (istat_q & ~iclr) | evt;
            wstat_q <= (wstat_q & ~wclr) | (evt & wmask_q);
        end
    end

    always_comb begin
        case (sel_i)
            SEL_RISE:  rdata_o = rise_q;
            SEL_FALL:  rdata_o = fall_q;
            SEL_IMASK: rdata_o = imask_q;
            SEL_ISTAT: rdata_o = istat_q;
            SEL_LTYPE: rdata_o = ltype_q;
            SEL_LPOL:  rdata_o = lpol_q;
            SEL_WMASK: rdata_o = wmask_q;
            SEL_WSTAT: rdata_o = wstat_q;
            default:   rdata_o = '0;
        endcase
    end

    assign rise_o  = rise_q;
    assign fall_o  = fall_q;
    assign imask_o = imask_q;
    assign istat_o = istat_q;
    assign wmask_o = wmask_q;
    assign wstat_o = wstat_q;
    assign evt_o   = evt;
    assign iclr_o  = iclr;
    assign wclr_o  = wclr;

endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 64
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_PINS-1:0]   pin_level_i,
    input  logic                  reg_wr_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [BANK_W-1:0]     reg_wdata_i,
    output logic [BANK_W-1:0]     reg_rdata_o,
    output logic                  irq_o,
    output logic                  wake_o
);

    localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int unsigned NPAD      = NUM_BANKS * BANK_W;
    localparam int unsigned BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    reg_sel_e          sel;
    logic [BIDX_W-1:0] bank_idx;
    logic [NPAD-1:0]   pin_pad;

    logic [BANK_W-1:0] bank_rdata [NUM_BANKS];
    logic [NPAD-1:0]   rise_all, fall_all, imask_all, istat_all;
    logic [NPAD-1:0]   wmask_all, wstat_all, evt_all, iclr_all, wclr_all;

    assign pin_pad = NPAD'(pin_level_i);

    gpio_irq_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BIDX_W    (BIDX_W)
    ) dec_i (
        .addr_i (reg_addr_i),
        .sel_o  (sel),
        .bank_o (bank_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = reg_wr_i && (sel != SEL_NONE) && (bank_idx == BIDX_W'(b));

        gpio_irq_bank #(
            .BANK_IDX (b),
            .NUM_PINS (NUM_PINS)
        ) bank_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .pin_i   (pin_pad[b*BANK_W +: BANK_W]),
            .wr_i    (bank_wr),
            .sel_i   (sel),
            .wdata_i (reg_wdata_i),
            .rise_o  (rise_all[b*BANK_W +: BANK_W]),
            .fall_o  (fall_all[b*BANK_W +: BANK_W]),
            .imask_o (imask_all[b*BANK_W +: BANK_W]),
            .istat_o (istat_all[b*BANK_W +: BANK_W]),
            .wmask_o (wmask_all[b*BANK_W +: BANK_W]),
            .wstat_o (wstat_all[b*BANK_W +: BANK_W]),
            .evt_o   (evt_all[b*BANK_W +: BANK_W]),
            .iclr_o  (iclr_all[b*BANK_W +: BANK_W]),
            .wclr_o  (wclr_all[b*BANK_W +: BANK_W]),
            .rdata_o (bank_rdata[b])
        );
    end

    assign reg_rdata_o = (sel == SEL_NONE) ? '0 : bank_rdata[bank_idx];
    assign irq_o       = |(istat_all & imask_all);
    assign wake_o      = |wstat_all;

endmodule

// File: rtl/gpio_irq_checker.sv
`timescale 1ns/1ps
module gpio_irq_checker #(
    parameter int unsigned NPAD = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NPAD-1:0] rise_i,
    input logic [NPAD-1:0] fall_i,
    input logic [NPAD-1:0] istat_i,
    input logic [NPAD-1:0] wmask_i,
    input logic [NPAD-1:0] wstat_i,
    input logic [NPAD-1:0] evt_i,
    input logic [NPAD-1:0] iclr_i,
    input logic [NPAD-1:0] wclr_i
);

    // R2: edge enables come out of reset cleared
    a_r2_edge_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> (rise_i == '0 && fall_i == '0));

    // R7: a clear with no competing event empties the bit
    a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (istat_i & $past(iclr_i & ~evt_i)) == '0);

    // R7: an event always leaves its status bit set
    a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(evt_i) & ~istat_i) == '0);

    // R7: without event or clear, a status bit keeps its value
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((istat_i ^ $past(istat_i)) & ~$past(iclr_i | evt_i)) == '0);

    // R9: a wake bit only rises for an event on a wake-enabled pin
    a_r9_wake_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wstat_i & ~$past(wstat_i) & ~$past(wmask_i & evt_i)) == '0);

    // R9: a wake clear with no competing wake event empties the bit
    a_r9_wake_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wstat_i & $past(wclr_i & ~(evt_i & wmask_i))) == '0);

endmodule

bind gpio_irq_unit gpio_irq_checker #(.NPAD(NPAD)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise_all),
    .fall_i  (fall_all),
    .istat_i (istat_all),
    .wmask_i (wmask_all),
    .wstat_i (wstat_all),
    .evt_i   (evt_all),
    .iclr_i  (iclr_all),
    .wclr_i  (wclr_all)
);

// File: tb/gpio_irq_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb_top;

    localparam int NPINS = 64;

    // Register kinds: 0 rise, 1 fall, 2 imask, 3 istat, 4 type, 5 pol, 6 wmask, 7 wstat
    localparam logic [11:0] BASES [8] = '{12'h064, 12'h07c, 12'h0ac, 12'h0c4,
                                          12'h300, 12'h318, 12'h400, 12'h418};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        d_wr;
    logic [11:0] d_addr;
    logic [31:0] d_wdata;
    logic [NPINS-1:0] d_pins;
    logic [31:0] rdata;
    logic        irq, wake;

    int n_checks = 0;
    int n_err    = 0;

    // Bench's own view of the register state
    logic [NPINS-1:0] m_re, m_fe, m_im, m_is, m_ty, m_po, m_wm, m_ws, m_prev;

    always #2.5 clk = ~clk;

    gpio_irq_unit #(.NUM_PINS(NPINS)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_level_i (d_pins),
        .reg_wr_i    (d_wr),
        .reg_addr_i  (d_addr),
        .reg_wdata_i (d_wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    function automatic int find_kind(input logic [11:0] a, output int bank);
        bank = 0;
        for (int k = 0; k < 8; k++) begin
            if (a[1:0] == 2'b00 && a >= BASES[k] && a < BASES[k] + 12'd8) begin
                bank = int'((a - BASES[k]) >> 2);
                return k;
            end
        end
        return -1;
    endfunction

    function automatic logic [NPINS-1:0] model_event(input logic [NPINS-1:0] p);
        logic [NPINS-1:0] edges;
        edges = (p & ~m_prev & m_re) | (~p & m_prev & m_fe);
        return (m_ty & (p ^ m_po)) | (~m_ty & edges);
    endfunction

    function automatic logic [31:0] model_word(input logic [11:0] a);
        int b;
        int k;
        k = find_kind(a, b);
        case (k)
            0: return m_re[b*32 +: 32];
            1: return m_fe[b*32 +: 32];
            2: return m_im[b*32 +: 32];
            3: return m_is[b*32 +: 32];
            4: return m_ty[b*32 +: 32];
            5: return m_po[b*32 +: 32];
            6: return m_wm[b*32 +: 32];
            7: return m_ws[b*32 +: 32];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_re = '0; m_fe = '0; m_im = '0; m_is = '0;
            m_ty = '0; m_po = '0; m_wm = '0; m_ws = '0; m_prev = '0;
        end else begin
            logic [NPINS-1:0] ev, iclr, wclr;
            int k, b;
            ev = model_event(d_pins);
            iclr = '0;
            wclr = '0;
            k = d_wr ? find_kind(d_addr, b) : -1;
            if (k == 3) iclr[b*32 +: 32] = d_wdata;
            if (k == 7) wclr[b*32 +: 32] = d_wdata;
            m_is = (m_is & ~iclr) | ev;
            m_ws = (m_ws & ~wclr) | (ev & m_wm);
            case (k)
                0: m_re[b*32 +: 32] = d_wdata;
                1: m_fe[b*32 +: 32] = d_wdata;
                2: m_im[b*32 +: 32] = d_wdata;
                4: m_ty[b*32 +: 32] = d_wdata;
                5: m_po[b*32 +: 32] = d_wdata;
                6: m_wm[b*32 +: 32] = d_wdata;
                default: ;
            endcase
            m_prev = d_pins;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock with the given inputs, then check the two request lines.
    task automatic cycle(input string tag, input logic wr, input logic [11:0] a,
                         input logic [31:0] wd, input logic [NPINS-1:0] p);
        @(negedge clk);
        d_wr = wr; d_addr = a; d_wdata = wd; d_pins = p;
        @(posedge clk);
        #1;
        d_wr = 1'b0;
        chk({tag, "/R8 irq"}, {31'h0, irq}, {31'h0, |(m_is & m_im)});
        chk({tag, "/R9 wake"}, {31'h0, wake}, {31'h0, |m_ws});
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a);
        @(negedge clk);
        d_addr = a;
        #1;
        chk(tag, rdata, model_word(a));
    endtask

    logic [NPINS-1:0] pins;

    initial begin
        int unused_seed;
        rst_n = 1'b0; d_wr = 1'b0; d_addr = '0; d_wdata = '0; d_pins = '0;
        pins = '0;
        unused_seed = $urandom(32'd5150);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: everything reads zero after reset
        for (int k = 0; k < 8; k++) begin
            for (int b = 0; b < 2; b++) begin
                @(negedge clk);
                d_addr = BASES[k] + 12'(4 * b);
                #1;
                chk("R2 reset reg", rdata, 32'h0);
            end
        end
        chk("R2 irq low", {31'h0, irq}, 32'h0);
        chk("R2 wake low", {31'h0, wake}, 32'h0);

        // R1: bank stride, readback, unmapped address
        cycle("R1", 1'b1, 12'h068, 32'hA5A5_5A5A, pins);
        rd_chk("R1 rise bank1", 12'h068);
        chk("R1 rise bank1 const", rdata, 32'hA5A5_5A5A);
        rd_chk("R1 rise bank0 untouched", 12'h064);
        cycle("R1", 1'b1, 12'h31c, 32'h0000_00F0, pins);
        rd_chk("R1 pol bank1", 12'h31c);
        cycle("R1", 1'b1, 12'h100, 32'hFFFF_FFFF, pins);
        rd_chk("R1 unmapped", 12'h100);
        chk("R1 unmapped const", rdata, 32'h0);
        rd_chk("R1 misaligned", 12'h066);
        cycle("R1", 1'b1, 12'h068, 32'h0, pins);
        cycle("R1", 1'b1, 12'h31c, 32'h0, pins);

        // R3: rising edge, once per transition
        cycle("R3", 1'b1, 12'h064, 32'h0000_0001, pins);
        cycle("R3", 1'b1, 12'h0ac, 32'h0000_0001, pins);
        pins[0] = 1'b1;
        cycle("R3", 1'b0, 12'h0, 32'h0, pins);
        rd_chk("R3 status after rise", 12'h0c4);
        chk("R3 status const", rdata, 32'h1);
        chk("R3 irq high", {31'h0, irq}, 32'h1);
        cycle("R3", 1'b1, 12'h0c4, 32'h1, pins);
        cycle("R3", 1'b0, 12'h0, 32'h0, pins);
        rd_chk("R3 no repeat while high", 12'h0c4);
        chk("R3 cleared const", rdata, 32'h0);

        // R5: edge pin without enables
        pins[1] = 1'b1;
        cycle("R5", 1'b0, 12'h0, 32'h0, pins);
        pins[1] = 1'b0;
        cycle("R5", 1'b0, 12'h0, 32'h0, pins);
        rd_chk("R5 no enable no status", 12'h0c4);

        // R4: falling and both edges
        cycle("R4", 1'b1, 12'h07c, 32'h0000_0005, pins);
        cycle("R4", 1'b1, 12'h064, 32'h0000_0004, pins);
        pins[0] = 1'b0;
        cycle("R4", 1'b0, 12'h0, 32'h0, pins);
        rd_chk("R4 falling", 12'h0c4);
        cycle("R4", 1'b1, 12'h0c4, 32'hFFFF_FFFF, pins);
        pins[2] = 1'b1;
        cycle("R4", 1'b0, 12'h0, 32'h0, pins);
        rd_chk("R4 both rise", 12'h0c4);
        cycle("R4", 1'b1, 12'h0c4, 32'h4, pins);
        pins[2] = 1'b0;
        cycle("R4", 1'b0, 12'h0, 32'h0, pins);
        rd_chk("R4 both fall", 12'h0c4);
        chk("R4 both fall const", rdata, 32'h4);
        cycle("R4", 1'b1, 12'h0c4, 32'h4, pins);

        // R6: level sensing, active high then active low
        cycle("R6", 1'b1, 12'h300, 32'h0000_0008, pins);
        pins[3] = 1'b1;
        cycle("R6", 1'b0, 12'h0, 32'h0, pins);
        cycle("R6", 1'b1, 12'h0c4, 32'h8, pins);
        rd_chk("R6 clear fails while active", 12'h0c4);
        chk("R6 still set const", rdata, 32'h8);
        pins[3] = 1'b0;
        cycle("R6", 1'b0, 12'h0, 32'h0, pins);
        cycle("R6", 1'b1, 12'h0c4, 32'h8, pins);
        rd_chk("R6 clear after inactive", 12'h0c4);
        cycle("R6", 1'b1, 12'h318, 32'h0000_0010, pins);
        cycle("R6", 1'b1, 12'h300, 32'h0000_0018, pins);
        cycle("R6", 1'b0, 12'h0, 32'h0, pins);
        rd_chk("R6 active low", 12'h0c4);
        pins[4] = 1'b1;
        cycle("R6", 1'b0, 12'h0, 32'h0, pins);
        cycle("R6", 1'b1, 12'h0c4, 32'h10, pins);
        rd_chk("R6 active low cleared", 12'h0c4);

        // R7: write zero no effect, event beats clear
        cycle("R7", 1'b1, 12'h064, 32'h0000_0060, pins);
        pins[5] = 1'b1;
        cycle("R7", 1'b0, 12'h0, 32'h0, pins);
        cycle("R7", 1'b1, 12'h0c4, 32'h0, pins);
        rd_chk("R7 write zero keeps", 12'h0c4);
        pins[6] = 1'b1;
        cycle("R7", 1'b1, 12'h0c4, 32'h60, pins);
        rd_chk("R7 event wins", 12'h0c4);
        chk("R7 event wins const", rdata, 32'h40);

        // R8: masked status still latches; mask gates irq
        cycle("R8", 1'b1, 12'h0ac, 32'h0, pins);
        chk("R8 masked irq low", {31'h0, irq}, 32'h0);
        rd_chk("R8 masked status kept", 12'h0c4);
        cycle("R8", 1'b1, 12'h0ac, 32'h40, pins);
        chk("R8 unmasked irq high", {31'h0, irq}, 32'h1);
        cycle("R8", 1'b1, 12'h0c4, 32'hFFFF_FFFF, pins);

        // R9: wake gating on bank1 pins 32 and 33
        cycle("R9", 1'b1, 12'h068, 32'h0000_0003, pins);
        cycle("R9", 1'b1, 12'h404, 32'h0000_0001, pins);
        pins[32] = 1'b1; pins[33] = 1'b1;
        cycle("R9", 1'b0, 12'h0, 32'h0, pins);
        rd_chk("R9 wake status", 12'h41c);
        chk("R9 wake status const", rdata, 32'h1);
        rd_chk("R9 int status bank1", 12'h0c8);
        chk("R9 wake high", {31'h0, wake}, 32'h1);
        cycle("R9", 1'b1, 12'h41c, 32'h1, pins);
        rd_chk("R9 wake cleared", 12'h41c);
        chk("R9 wake low", {31'h0, wake}, 32'h0);

        // Random phase
        for (int it = 0; it < 3000; it++) begin
            logic [NPINS-1:0] flip;
            logic [11:0] a;
            logic        w;
            flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            pins = pins ^ flip;
            w = ($urandom % 2) == 0;
            a = BASES[$urandom % 8] + 12'(4 * ($urandom % 2));
            cycle("RND R3 R4 R6", w, a, $urandom, pins);
            rd_chk("RND R1 R7 R9", BASES[$urandom % 8] + 12'(4 * ($urandom % 2)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule